// File: doc/BRIEF.md
# Flash error-protect control register

This block is the 8-bit control and status register of an on-chip flash controller. It keeps a sticky error flag that hardware sets when something unsafe happens around a program or erase operation. While the flag is set, the block drives an error-protect output, and the flash sequencer must then refuse every program and erase request. Only a reset or entry to hardware standby clears the flag. Software cannot write it.

The same register holds a RAM-select bit and an area code. The address remapping logic uses these to overlay a RAM window onto a flash area for emulation. Setting the RAM-select bit locks all flash blocks against programming and erasing, whatever the area code holds.

Event strobes come from the CPU core and the bus logic:
- flash reads, instruction fetches and vector fetches;
- qualified exceptions;
- sleep instructions;
- bus release.

The block qualifies each strobe against the program/erase activity signal.

Top module: `flash_guard_reg`

## Requirements
- R1: After reset, `reg_rd_data` reads 8'h70, and `err_protect`, `pe_inhibit` and `overlay_en` are all 0.
- R2: `reg_rd_data` is combinational from the stored state and has this layout: bit 7 is the error flag, bits 6..4 always read 1, bit 3 is RAM-select, and bits 2..0 are the area code.
- R3: A write (`reg_wr_en`=1) loads `reg_wr_data[3:0]` into RAM-select and the area code at the next clock edge. The written values of bits 7..4 have no effect on the register.
- R4: A `flash_rd` strobe in a cycle with `pe_active`=1 sets the error flag at the next edge. The strobe has no effect when `rd_overlay`=1 or when `pe_active`=0.
- R5: `exc_strobe` carries a 3-bit `exc_kind`. Kinds 0 to 4 (reset, trace, invalid instruction, trap, zero divide) are excluded, and kinds 5 to 7 qualify. The flag sets only when a qualified strobe occurs exactly one cycle before the cycle in which `pe_active` goes from 0 to 1. A strobe in the same cycle, or two cycles earlier, has no effect.
- R6: A `sleep_exec` or `bus_release` strobe with `pe_active`=1 sets the flag at the next edge. If several events coincide, the flag simply becomes 1.
- R7: Once set, the flag stays 1 through writes and further events until reset or `hw_standby`. `hw_standby` clears it at the next edge and wins over a set event in the same cycle.
- R8: `err_protect` equals the flag. `pe_inhibit` is 1 whenever the flag or RAM-select is 1. `overlay_en` equals RAM-select.
- R9: `area_onehot` has exactly bit N set, where N is the stored area code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby entry; clears the error flag |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_data | output | 8 | Live register read value |
| pe_active | input | 1 | Program or erase enable is active |
| flash_rd | input | 1 | Flash read, instruction fetch or vector fetch |
| rd_overlay | input | 1 | The current read hits the RAM overlay window |
| exc_strobe | input | 1 | Exception handling sequence starts |
| exc_kind | input | 3 | Exception class code |
| sleep_exec | input | 1 | Sleep instruction executed |
| bus_release | input | 1 | Bus granted to another master |
| err_protect | output | 1 | Error-protect mode is in force |
| pe_inhibit | output | 1 | All flash blocks are locked against program and erase |
| overlay_en | output | 1 | RAM overlay is selected |
| area_onehot | output | 8 | One-hot decode of the area code |

## Verification
On every cycle the assertions check four things:
- the flag stays set until standby;
- standby clears it;
- the flag never rises unless program/erase was active;
- written low bits land one edge later.

They also check that the area decode stays one-hot. Only the bench scenarios can show which event combinations set the flag and which do not. This covers the overlay read exemption, the exact one-cycle exception window with its excluded kinds, and the priority of standby over a simultaneous set.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
    // Register geometry
    localparam int GUARD_REG_W  = 8;
    localparam int GUARD_AREA_W = 3;
    // Exception classification: codes below this value are excluded
    localparam int GUARD_KIND_W     = 3;
    localparam int GUARD_FIRST_QUAL = 5;

    typedef struct packed {
        logic exc_hit;
        logic pe_prev;
    } qual_state_t;
endpackage

// File: rtl/fg_event_qual.sv
module fg_event_qual
    import flash_guard_pkg::*;
#(
    parameter int KIND_W     = GUARD_KIND_W,
    parameter int FIRST_QUAL = GUARD_FIRST_QUAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pe_active,
    input  logic              flash_rd,
    input  logic              rd_overlay,
    input  logic              sleep_exec,
    input  logic              bus_release,
    input  logic              exc_strobe,
    input  logic [KIND_W-1:0] exc_kind,
    output logic              set_req
);
    qual_state_t st_d, st_q;
    logic        pe_rise;
    logic        during_pe;

    always_comb begin
        st_d         = st_q;
        st_d.exc_hit = exc_strobe && (exc_kind >= KIND_W'(FIRST_QUAL));
        st_d.pe_prev = pe_active;
        pe_rise      = pe_active && !st_q.pe_prev;
        during_pe    = pe_active && ((flash_rd && !rd_overlay) || sleep_exec || bus_release);
        set_req      = during_pe || (st_q.exc_hit && pe_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4 R5 R6: no set request ever arises outside program/erase activity
    p_set_needs_pe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |-> pe_active);
endmodule

// File: rtl/fg_area_decode.sv
module fg_area_decode
    import flash_guard_pkg::*;
#(
    parameter int AREA_W = GUARD_AREA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREA_W-1:0] area,
    output logic [(1<<AREA_W)-1:0] onehot
);
    localparam int NAREA = 1 << AREA_W;

    for (genvar i = 0; i < NAREA; i++) begin : g_area
        assign onehot[i] = (area == AREA_W'(i));
    end

    // R9: exactly one area line active
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(onehot) == 1);
endmodule

// File: rtl/flash_guard_reg.sv
module flash_guard_reg
    import flash_guard_pkg::*;
#(
    parameter int REG_W      = GUARD_REG_W,
    parameter int AREA_W     = GUARD_AREA_W,
    parameter int KIND_W     = GUARD_KIND_W,
    parameter int FIRST_QUAL = GUARD_FIRST_QUAL
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hw_standby,
    input  logic                   reg_wr_en,
    input  logic [REG_W-1:0]       reg_wr_data,
    output logic [REG_W-1:0]       reg_rd_data,
    input  logic                   pe_active,
    input  logic                   flash_rd,
    input  logic                   rd_overlay,
    input  logic                   exc_strobe,
    input  logic [KIND_W-1:0]      exc_kind,
    input  logic                   sleep_exec,
    input  logic                   bus_release,
    output logic                   err_protect,
    output logic                   pe_inhibit,
    output logic                   overlay_en,
    output logic [(1<<AREA_W)-1:0] area_onehot
);
    localparam int RSV_W   = REG_W - 2 - AREA_W;
    localparam int SEL_BIT = AREA_W;

    typedef struct packed {
        logic              err;
        logic              ram_sel;
        logic [AREA_W-1:0] area;
    } guard_state_t;

    guard_state_t st_d, st_q;
    logic         set_req;

    fg_event_qual #(.KIND_W(KIND_W), .FIRST_QUAL(FIRST_QUAL)) i_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .pe_active  (pe_active),
        .flash_rd   (flash_rd),
        .rd_overlay (rd_overlay),
        .sleep_exec (sleep_exec),
        .bus_release(bus_release),
        .exc_strobe (exc_strobe),
        .exc_kind   (exc_kind),
        .set_req    (set_req)
    );

    fg_area_decode #(.AREA_W(AREA_W)) i_area (
        .clk   (clk),
        .rst_n (rst_n),
        .area  (st_q.area),
        .onehot(area_onehot)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr_en) begin
            st_d.ram_sel = reg_wr_data[SEL_BIT];
            st_d.area    = reg_wr_data[AREA_W-1:0];
        end
        if (set_req)    st_d.err = 1'b1;
        if (hw_standby) st_d.err = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rd_data = {st_q.err, {RSV_W{1'b1}}, st_q.ram_sel, st_q.area};
    assign err_protect = st_q.err;
    assign pe_inhibit  = st_q.err | st_q.ram_sel;
    assign overlay_en  = st_q.ram_sel;

    // R7: the flag holds until standby
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_protect && !hw_standby |=> err_protect);
    // R7: standby clears the flag
    p_standby_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> !err_protect);
    // R4: the flag only rises after a cycle with program/erase active
    p_rise_in_pe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_protect) |-> $past(pe_active));
    // R3: written low bits are visible one edge later
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> reg_rd_data[SEL_BIT:0] == $past(reg_wr_data[SEL_BIT:0]));
endmodule

// File: tb/test_flash_guard_reg.sv
module test_flash_guard_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_standby = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic       pe_active = 1'b0;
    logic       flash_rd = 1'b0;
    logic       rd_overlay = 1'b0;
    logic       exc_strobe = 1'b0;
    logic [2:0] exc_kind = '0;
    logic       sleep_exec = 1'b0;
    logic       bus_release = 1'b0;
    logic       err_protect, pe_inhibit, overlay_en;
    logic [7:0] area_onehot;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    flash_guard_reg i_flash_guard_reg (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .pe_active(pe_active), .flash_rd(flash_rd), .rd_overlay(rd_overlay),
        .exc_strobe(exc_strobe), .exc_kind(exc_kind),
        .sleep_exec(sleep_exec), .bus_release(bus_release),
        .err_protect(err_protect), .pe_inhibit(pe_inhibit),
        .overlay_en(overlay_en), .area_onehot(area_onehot)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        hw_standby = 0; reg_wr_en = 0; pe_active = 0; flash_rd = 0;
        rd_overlay = 0; exc_strobe = 0; sleep_exec = 0; bus_release = 0;
    endtask

    task automatic clear_flag();
        idle_inputs();
        hw_standby = 1;
        @(posedge clk); @(negedge clk);
        hw_standby = 0;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        reg_wr_en = 1; reg_wr_data = v;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rd", reg_rd_data, 8'h70);
        check("R1 outs", {5'd0, err_protect, pe_inhibit, overlay_en}, 8'h00);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R8 R9: sweep all low nibbles with varied upper bits
        for (int v = 0; v < 16; v++) begin
            logic [7:0] w;
            w = {4'(v * 7 + 3), 4'(v)};
            wr(w);
            check("R3 R2 rd", reg_rd_data, {1'b0, 3'b111, 4'(v)});
            check("R9 onehot", area_onehot, 8'(1) << (v % 8));
            check("R8 inhibit", {6'd0, pe_inhibit, overlay_en}, {6'd0, 1'(v >= 8), 1'(v >= 8)});
        end
        wr(8'h00);

        // R4 R6: sweep {pe, rd, overlay, sleep, bus}
        for (int c = 0; c < 32; c++) begin
            logic e;
            clear_flag();
            pe_active = c[4]; flash_rd = c[3]; rd_overlay = c[2];
            sleep_exec = c[1]; bus_release = c[0];
            e = c[4] & ((c[3] & ~c[2]) | c[1] | c[0]);
            @(posedge clk); @(negedge clk);
            idle_inputs();
            check("R4 R6 flag", {7'd0, err_protect}, {7'd0, e});
            check("R2 R8 rd bit7", {7'd0, reg_rd_data[7]}, {7'd0, e});
            check("R8 inhibit", {7'd0, pe_inhibit}, {7'd0, e});
        end

        // R5: exception kinds vs timing offsets
        for (int k = 0; k < 8; k++) begin
            for (int d = 0; d < 3; d++) begin
                clear_flag();
                exc_strobe = 1; exc_kind = 3'(k);
                if (d == 0) pe_active = 1;
                @(posedge clk); @(negedge clk);
                exc_strobe = 0;
                if (d == 2) begin
                    @(posedge clk); @(negedge clk);
                end
                if (d != 0) begin
                    pe_active = 1;
                    @(posedge clk); @(negedge clk);
                end
                check("R5 exc window", {7'd0, err_protect}, {7'd0, 1'((d == 1) && (k >= 5))});
                pe_active = 0;
            end
        end

        // R7: sticky through writes and idle, cleared by standby
        clear_flag();
        pe_active = 1; bus_release = 1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        wr(8'h00);
        repeat (5) @(negedge clk);
        check("R7 sticky", {7'd0, err_protect}, 8'h01);
        check("R7 rd", reg_rd_data, 8'hF0);
        // R7: standby wins over coincident set
        hw_standby = 1; pe_active = 1; sleep_exec = 1; flash_rd = 1;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check("R7 standby wins", {7'd0, err_protect}, 8'h00);
        // R8: RAM-select alone inhibits
        wr(8'h0D);
        check("R8 sel inhibit", {6'd0, pe_inhibit, err_protect}, 8'h02);
        check("R9 onehot", area_onehot, 8'h20);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule